// File: doc/BRIEF.md
# Threshold Alarm Engine

This block watches a stream of sensor samples and raises alarms when they cross programmable limits. It serves four channels: three inertial channels (X, Y, Z) that each see an acceleration sample and an inclination sample, and one system channel that sees a temperature sample and a supply sample. A single sample-valid strobe marks the cycle in which all eight sample inputs hold fresh data. The block evaluates alarms only in that cycle.

Each channel has an enable, a source select, a trigger polarity and, on the inertial channels, a choice between a static compare and a rate-of-change compare. A static compare checks the sample against the channel's limit register. A rate-of-change compare keeps a reference sample. After a programmable number of further samples it compares the change since that reference with the channel's limit register, which then acts as a magnitude. It then takes the current sample as the next reference. Alarms are sticky. A clear command on the register-write port drops all of them. A combined indicator shows whether any alarm is set.

Software programs the block through a simple synchronous write port. Writes take effect at the next clock edge. The sample path carries no handshake.

Top module: `thr_alarm_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `alarm_flags` is 0 and `alarm_any` is 0. All control, limit and period registers reset to 0, so every channel starts disabled.
- R2: Static compare with polarity 0 raises a channel's flag when the selected sample is strictly below the channel limit, compared as signed two's complement. An equal sample does not raise the flag.
- R3: Static compare with polarity 1 raises the flag when the selected sample is strictly above the limit, compared as signed. An equal sample does not raise the flag.
- R4: The control word at address 0 has these fields: enable bits [3:0], source bits [7:4], polarity bits [11:8] and rate-mode bits [14:12]. Within each field, bit offset 0, 1, 2 and 3 serve X, Y, Z and S. An inertial source bit of 1 selects the inclination sample and 0 selects the acceleration sample.
- R5: For the system channel, source bit 7 = 0 selects the temperature sample and 1 selects the supply sample. Its enable is bit 3 and its polarity is bit 11. It always uses static compare against the limit at address 4.
- R6: A set flag stays set while no clear command is written, even when later samples no longer meet the condition.
- R7: A write to address 8 with data bit 0 = 1 clears all four flags at that clock edge. Clear wins over an alarm condition in the same cycle.
- R8: No flag rises in a cycle where `smp_valid` is low, whatever the sample inputs carry.
- R9: A channel whose enable bit is 0 never raises its flag.
- R10: In rate mode, a channel compares the change from its reference sample to the N-th valid sample after it. N is the channel's period register: addresses 5, 6 and 7 for X, Y and Z. The limit register holds the magnitude. Polarity 1 raises the flag when the rise (current minus reference) is strictly greater than the magnitude. Polarity 0 raises it when the fall (reference minus current) is strictly greater. The N-th sample then becomes the new reference.
- R11: After enable, after leaving static mode, or after a clear, a rate-mode channel takes the first valid sample as its reference and evaluates nothing before N more valid samples arrive. A period of 0 behaves as 1.
- R12: `alarm_flags` bit 0 to 3 carry X, Y, Z and S. `alarm_any` is high in exactly the cycles where at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | DW (16) | Register write data |
| smp_valid | input | 1 | All sample inputs carry a new sample this cycle |
| acc_x | input | DW | X acceleration sample, signed |
| acc_y | input | DW | Y acceleration sample, signed |
| acc_z | input | DW | Z acceleration sample, signed |
| inc_x | input | DW | X inclination sample, signed |
| inc_y | input | DW | Y inclination sample, signed |
| inc_z | input | DW | Z inclination sample, signed |
| temp_smp | input | DW | Temperature sample, signed |
| supply_smp | input | DW | Supply sample, signed |
| alarm_flags | output | 4 | Sticky alarm flags: X, Y, Z, S in bits 0 to 3 |
| alarm_any | output | 1 | OR of all alarm flags |

## Verification
The assertions assume that `wr_en`, `wr_addr`, `wr_data` and `smp_valid` are driven to known values from the first clock onward. They also assume that a clear is a single-cycle write, so a flag may only fall in the cycle after a clear command. The stimulus drives every input on the falling edge and never leaves one undriven. It keeps configuration writes out of sample cycles, except in one deliberate case that puts a clear and a triggering sample in the same cycle.

// File: rtl/alm_pkg.sv
// Package: shared constants for the threshold alarm engine.
// Assumes a 16-bit control word with four-bit fields per channel.
package alm_pkg;
    localparam int NCH    = 4;   // channels: X, Y, Z, S
    localparam int NDYN   = 3;   // channels that support rate mode
    localparam int F_EN   = 0;   // enable field base bit
    localparam int F_SRC  = 4;   // source select field base bit
    localparam int F_POL  = 8;   // polarity field base bit
    localparam int F_MODE = 12;  // rate-mode field base bit
    localparam int A_CTRL = 0;   // control word address
    localparam int A_THR0 = 1;   // first limit register (X..S follow)
    localparam int A_PER0 = 5;   // first period register (X..Z follow)
    localparam int A_CMD  = 8;   // command address
    localparam int CMD_CLR_BIT = 0;
endpackage

// File: rtl/alm_regs.sv
// Module: alm_regs
// Holds the control word, per-channel limits and per-axis periods.
// Decodes the clear command into a one-cycle pulse, combinationally,
// so that the clear acts at the same edge as the write.
// Assumes writes to unmapped addresses are simply dropped.
module alm_regs
    import alm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] thr [NCH],
    output logic [PW-1:0] per [NDYN],
    output logic          clr
);
    // Register file update on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            for (int i = 0; i < NCH; i++)  thr[i] <= '0;
            for (int i = 0; i < NDYN; i++) per[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_CTRL)) ctrl <= wr_data;
            for (int i = 0; i < NCH; i++)
                if (wr_addr == AW'(A_THR0 + i)) thr[i] <= wr_data;
            for (int i = 0; i < NDYN; i++)
                if (wr_addr == AW'(A_PER0 + i)) per[i] <= wr_data[PW-1:0];
        end
    end

    // Clear command decode.
    always_comb begin
        clr = wr_en && (wr_addr == AW'(A_CMD)) && wr_data[CMD_CLR_BIT];
    end
endmodule

// File: rtl/alm_rate.sv
// Module: alm_rate
// Rate-of-change detector for one channel. It holds a reference sample,
// counts valid samples, and on the N-th one compares the signed change
// against a magnitude, then takes that sample as the next reference.
// Assumes run drops for at least one cycle on disable or clear, which
// re-arms the window.
module alm_rate #(
    parameter int DW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          valid,
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] mag,
    input  logic [PW-1:0] per,
    input  logic          pol,
    output logic          hit
);
    logic                 armed;
    logic [DW-1:0]        refv;
    logic [PW:0]          cnt;
    logic [PW:0]          cnt_nx;
    logic [PW:0]          lim;
    logic                 last;
    logic signed [DW+1:0] rise;
    logic signed [DW+1:0] fall;
    logic signed [DW+1:0] magx;

    // Window length, change values and the end-of-window condition.
    always_comb begin
        lim    = (per == '0) ? (PW+1)'(1) : {1'b0, per};
        cnt_nx = cnt + (PW+1)'(1);
        last   = armed && (cnt_nx >= lim);
        rise   = $signed({{2{smp[DW-1]}}, smp}) - $signed({{2{refv[DW-1]}}, refv});
        fall   = $signed({{2{refv[DW-1]}}, refv}) - $signed({{2{smp[DW-1]}}, smp});
        magx   = $signed({{2{mag[DW-1]}}, mag});
        hit    = valid && last && (pol ? (rise > magx) : (fall > magx));
    end

    // Reference capture and sample counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            refv  <= '0;
            cnt   <= '0;
        end else if (!run) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (valid) begin
            if (!armed || last) begin
                refv  <= smp;
                armed <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/alm_chan.sv
// Module: alm_chan
// One alarm channel: selects between two sample sources, applies a
// static or (when HAS_DYN) rate-of-change compare, and keeps a sticky
// flag that only the clear pulse drops. Clear has priority over a hit.
// Assumes inputs are sampled only when valid is high.
module alm_chan #(
    parameter int DW      = 16,
    parameter int PW      = 16,
    parameter bit HAS_DYN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          src,
    input  logic          pol,
    input  logic          dyn,
    input  logic          clr,
    input  logic          valid,
    input  logic [DW-1:0] smp_a,
    input  logic [DW-1:0] smp_b,
    input  logic [DW-1:0] thr,
    input  logic [PW-1:0] per,
    output logic          flag
);
    logic [DW-1:0] sel;
    logic          st_hit;
    logic          dyn_hit;
    logic          use_dyn;
    logic          hit;

    // Source selection and static compare.
    always_comb begin
        sel    = src ? smp_b : smp_a;
        st_hit = pol ? ($signed(sel) > $signed(thr)) : ($signed(sel) < $signed(thr));
    end

    generate
        if (HAS_DYN) begin : g_dyn
            alm_rate #(.DW(DW), .PW(PW)) u_rate (
                .clk   (clk),
                .rst_n (rst_n),
                .run   (en && dyn && !clr),
                .valid (valid),
                .smp   (sel),
                .mag   (thr),
                .per   (per),
                .pol   (pol),
                .hit   (dyn_hit)
            );
            assign use_dyn = dyn;
        end else begin : g_static
            logic unused_rate;
            assign unused_rate = ^{per, dyn};
            assign dyn_hit     = 1'b0;
            assign use_dyn     = 1'b0;
        end
    endgenerate

    // Qualified alarm condition.
    always_comb begin
        hit = en && valid && (use_dyn ? dyn_hit : st_hit);
    end

    // Sticky flag with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (hit) flag <= 1'b1;
    end
endmodule

// File: rtl/thr_alarm_engine.sv
// Module: thr_alarm_engine (top)
// Four-channel threshold alarm engine. Channels X, Y, Z choose between
// acceleration and inclination samples and support static or
// rate-of-change compares; channel S chooses temperature or supply and
// is static only. Flags are sticky; alarm_any is their OR.
// Assumes all sample inputs are valid together under smp_valid.
module thr_alarm_engine
    import alm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          smp_valid,
    input  logic [DW-1:0] acc_x,
    input  logic [DW-1:0] acc_y,
    input  logic [DW-1:0] acc_z,
    input  logic [DW-1:0] inc_x,
    input  logic [DW-1:0] inc_y,
    input  logic [DW-1:0] inc_z,
    input  logic [DW-1:0] temp_smp,
    input  logic [DW-1:0] supply_smp,
    output logic [NCH-1:0] alarm_flags,
    output logic          alarm_any
);
    logic [DW-1:0] ctrl;
    logic [DW-1:0] thr [NCH];
    logic [PW-1:0] per [NDYN];
    logic          clr;
    logic [DW-1:0] smp_a [NCH];
    logic [DW-1:0] smp_b [NCH];
    logic          unused_ctrl;

    alm_regs #(.DW(DW), .AW(AW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .thr     (thr),
        .per     (per),
        .clr     (clr)
    );

    // Route the sample inputs to per-channel source pairs.
    always_comb begin
        smp_a[0] = acc_x;    smp_b[0] = inc_x;
        smp_a[1] = acc_y;    smp_b[1] = inc_y;
        smp_a[2] = acc_z;    smp_b[2] = inc_z;
        smp_a[3] = temp_smp; smp_b[3] = supply_smp;
    end

    assign unused_ctrl = ^ctrl[DW-1:F_MODE+NDYN];

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            if (ch < NDYN) begin : g_axis
                alm_chan #(.DW(DW), .PW(PW), .HAS_DYN(1'b1)) u_chan (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (ctrl[F_EN + ch]),
                    .src   (ctrl[F_SRC + ch]),
                    .pol   (ctrl[F_POL + ch]),
                    .dyn   (ctrl[F_MODE + ch]),
                    .clr   (clr),
                    .valid (smp_valid),
                    .smp_a (smp_a[ch]),
                    .smp_b (smp_b[ch]),
                    .thr   (thr[ch]),
                    .per   (per[ch]),
                    .flag  (alarm_flags[ch])
                );
            end else begin : g_sys
                alm_chan #(.DW(DW), .PW(PW), .HAS_DYN(1'b0)) u_chan (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (ctrl[F_EN + ch]),
                    .src   (ctrl[F_SRC + ch]),
                    .pol   (ctrl[F_POL + ch]),
                    .dyn   (1'b0),
                    .clr   (clr),
                    .valid (smp_valid),
                    .smp_a (smp_a[ch]),
                    .smp_b (smp_b[ch]),
                    .thr   (thr[ch]),
                    .per   ('0),
                    .flag  (alarm_flags[ch])
                );
            end
        end
    endgenerate

    // Combined indicator.
    always_comb begin
        alarm_any = |alarm_flags;
    end
endmodule

// File: rtl/alm_engine_chk.sv
// Module: alm_engine_chk
// Property checker for thr_alarm_engine, attached by bind below.
// Assumes inputs are known from the first clock edge.
module alm_engine_chk
    import alm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          smp_valid,
    input logic [DW-1:0] ctrl,
    input logic [NCH-1:0] alarm_flags
);
    logic clr_cmd;
    assign clr_cmd = wr_en && (wr_addr == AW'(A_CMD)) && wr_data[CMD_CLR_BIT];

    // R1: a reset cycle leaves all flags low.
    a_r1_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (alarm_flags == '0));

    // R8: no flag rises after a cycle without a valid sample.
    a_r8_no_rise_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ((alarm_flags & ~$past(alarm_flags)) == '0));

    // R7: a clear command leaves all flags low.
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (alarm_flags == '0));

    // R6: without a clear, no set flag falls.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((alarm_flags & $past(alarm_flags)) == $past(alarm_flags)));

    // R9: with every channel disabled, no flag rises.
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[F_EN +: NCH] == '0) |=> ((alarm_flags & ~$past(alarm_flags)) == '0));
endmodule

bind thr_alarm_engine alm_engine_chk #(.DW(DW), .AW(AW)) u_alm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .smp_valid   (smp_valid),
    .ctrl        (ctrl),
    .alarm_flags (alarm_flags)
);

// File: tb/test_thr_alarm_engine.sv
// Bench for thr_alarm_engine: a vector table of static cases, then
// directed tests for reset, strobe gating, stickiness, clear and rate mode.
module test_thr_alarm_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        smp_valid;
    logic [15:0] acc_x, acc_y, acc_z, inc_x, inc_y, inc_z, temp_smp, supply_smp;
    logic [3:0]  alarm_flags;
    logic        alarm_any;
    int          total = 0;
    int          bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    thr_alarm_engine i_thr_alarm_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .smp_valid(smp_valid), .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .inc_x(inc_x), .inc_y(inc_y), .inc_z(inc_z), .temp_smp(temp_smp),
        .supply_smp(supply_smp), .alarm_flags(alarm_flags), .alarm_any(alarm_any)
    );

    // Static cases: ctrl, limit (all channels), acc, inc, temp, supply, expected flags.
    localparam int NV = 9;
    localparam logic [99:0] TBL [NV] = '{
        {16'h000F, 16'h0100, 16'h00FF, 16'h7000, 16'h0000, 16'h7000, 4'hF}, // R2 below
        {16'h000F, 16'h0100, 16'h0100, 16'h7000, 16'h0100, 16'h7000, 4'h0}, // R2 equal
        {16'h0F0F, 16'h0100, 16'h0101, 16'h0000, 16'h0100, 16'h7000, 4'h7}, // R3 above
        {16'h00F7, 16'h0000, 16'hFFFF, 16'h0005, 16'h8000, 16'h8000, 4'h0}, // R4 inc, R9
        {16'h00F7, 16'h0000, 16'h0005, 16'h8000, 16'h8000, 16'h8000, 4'h7}, // R4 signed
        {16'h0808, 16'h1000, 16'h0000, 16'h0000, 16'h1001, 16'h0000, 4'h8}, // R5 temp
        {16'h0888, 16'h1000, 16'h0000, 16'h0000, 16'h1001, 16'h0FFF, 4'h0}, // R5 supply
        {16'h0888, 16'h1000, 16'h0000, 16'h0000, 16'h0000, 16'h1001, 4'h8}, // R5 supply
        {16'h0002, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'h2}  // R9 one ch
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clear_cmd;
        wr(4'd8, 16'h0001);
    endtask

    task automatic set_smp(input logic [15:0] a, input logic [15:0] i,
                           input logic [15:0] t, input logic [15:0] s);
        acc_x = a; acc_y = a; acc_z = a;
        inc_x = i; inc_y = i; inc_z = i;
        temp_smp = t; supply_smp = s;
    endtask

    task automatic pulse(input logic [15:0] a, input logic [15:0] i,
                         input logic [15:0] t, input logic [15:0] s);
        set_smp(a, i, t, s);
        smp_valid = 1'b1;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic rate_setup(input logic [15:0] c, input logic [15:0] m, input logic [15:0] n);
        wr(4'd0, c);
        wr(4'd1, m);
        wr(4'd5, n);
        clear_cmd();
    endtask

    initial begin
        #(8 * 50000);
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; smp_valid = 1'b0;
        set_smp(16'h0, 16'h0, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", alarm_flags, 4'h0);
        chk("R1 any in reset", {3'b0, alarm_any}, 4'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 flags after reset", alarm_flags, 4'h0);
        // R9: reset leaves channels disabled, so an extreme sample sets nothing.
        pulse(16'h8000, 16'h8000, 16'h8000, 16'h8000);
        chk("R9 disabled after reset", alarm_flags, 4'h0);

        // Vector table walk: R2 R3 R4 R5 R9 R12.
        for (int v = 0; v < NV; v++) begin
            clear_cmd();
            wr(4'd0, TBL[v][99:84]);
            for (int a = 1; a <= 4; a++) wr(4'(a), TBL[v][83:68]);
            pulse(TBL[v][67:52], TBL[v][51:36], TBL[v][35:20], TBL[v][19:4]);
            chk($sformatf("R2/R3/R4/R5/R9 vector %0d", v), alarm_flags, TBL[v][3:0]);
            chk($sformatf("R12 any vector %0d", v), {3'b0, alarm_any},
                {3'b0, (TBL[v][3:0] != 4'h0)});
        end

        // R8: samples without strobe do nothing.
        clear_cmd();
        wr(4'd0, 16'h000F);
        for (int a = 1; a <= 4; a++) wr(4'(a), 16'h0100);
        set_smp(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        repeat (4) tick();
        chk("R8 no strobe", alarm_flags, 4'h0);
        pulse(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        chk("R8 with strobe", alarm_flags, 4'hF);

        // R6: sticky after the condition goes away.
        pulse(16'h0200, 16'h0200, 16'h0200, 16'h0200);
        chk("R6 sticky", alarm_flags, 4'hF);
        chk("R12 any set", {3'b0, alarm_any}, 4'h1);

        // R7: clear, then clear wins over a same-cycle hit.
        clear_cmd();
        chk("R7 clear", alarm_flags, 4'h0);
        chk("R12 any clear", {3'b0, alarm_any}, 4'h0);
        set_smp(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        smp_valid = 1'b1;
        wr(4'd8, 16'h0001);
        smp_valid = 1'b0;
        chk("R7 clear priority", alarm_flags, 4'h0);
        // R7: data bit 0 = 0 at the command address clears nothing.
        pulse(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        wr(4'd8, 16'h0000);
        chk("R7 no clear without bit 0", alarm_flags, 4'hF);

        // R10: rising rate on X, magnitude 10, period 3.
        rate_setup(16'h1101, 16'd10, 16'd3);
        pulse(16'd100, 16'd0, 16'd0, 16'd0);
        chk("R11 reference only", alarm_flags, 4'h0);
        pulse(16'd105, 16'd0, 16'd0, 16'd0);
        pulse(16'd108, 16'd0, 16'd0, 16'd0);
        pulse(16'd110, 16'd0, 16'd0, 16'd0);
        chk("R10 rise equal magnitude", alarm_flags, 4'h0);
        pulse(16'd111, 16'd0, 16'd0, 16'd0);
        pulse(16'd112, 16'd0, 16'd0, 16'd0);
        chk("R11 mid-window", alarm_flags, 4'h0);
        pulse(16'd121, 16'd0, 16'd0, 16'd0);
        chk("R10 rise above magnitude", alarm_flags, 4'h1);

        // R10/R11: falling rate, large swing inside window ignored.
        rate_setup(16'h1001, 16'd10, 16'd3);
        pulse(16'd200, 16'd0, 16'd0, 16'd0);
        pulse(16'd150, 16'd0, 16'd0, 16'd0);
        pulse(16'd150, 16'd0, 16'd0, 16'd0);
        chk("R11 holdoff before N", alarm_flags, 4'h0);
        pulse(16'd189, 16'd0, 16'd0, 16'd0);
        chk("R10 fall above magnitude", alarm_flags, 4'h1);

        // R11: period 0 acts as 1; first sample after clear is reference.
        rate_setup(16'h1101, 16'd10, 16'd0);
        pulse(16'd30000, 16'd0, 16'd0, 16'd0);
        chk("R11 first sample after clear", alarm_flags, 4'h0);
        pulse(16'd30011, 16'd0, 16'd0, 16'd0);
        chk("R11 period zero as one", alarm_flags, 4'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule